// File: doc/BRIEF.md
# Scalar Move Merge Writeback Unit

This unit is the writeback stage behind a 64-bit scalar move that targets a wide vector register. A decoder upstream supplies the operation form, the operand values and the masking controls. The unit then builds the new destination register value, or a store quadword with its enable. It also raises an undefined-opcode fault when a form that must not name an extra register carries a non-all-ones extra-register field. Every form writes the low quadword. The forms differ in how they handle bits 127:64 and the bits above 127: some keep the old contents, some clear them, and one copies them from the first source.

The masked forms write the low quadword under a single mask bit. The mask can leave the old quadword in place (merging) or clear it (zeroing). A store supports merging only, so a clear mask bit suppresses the memory write. Results are registered and appear one clock after the input strobe. Decoding of instruction bytes, memory access and the mask register file are handled elsewhere.

Top module: `scalar_merge_wb`

## Requirements
- R1: After reset every output is 0. `out_valid` follows `in_valid` by exactly one clock. While `out_valid` is 0, `rf_we`, `st_en` and `ud_fault` are 0.
- R2: Form code 0 (legacy register move): `rf_wdata[63:0]` = `qsrc`, bits VW-1:64 are copied from `dst_old`, the mask inputs have no effect, and `rf_we` = 1.
- R3: Form code 1 (legacy load): `rf_wdata[63:0]` = `qsrc`, bits 127:64 are 0, bits VW-1:128 are copied from `dst_old`, the mask inputs have no effect, and `rf_we` = 1.
- R4: Form code 2 (three-operand merge): the low quadword follows R6, bits 127:64 come from `vsrc1[127:64]`, bits VW-1:128 are 0, and `rf_we` = 1.
- R5: Form code 3 (masked load): the low quadword follows R6 and bits VW-1:64 are 0 whatever the mask bit is.
- R6: For form codes 2 and 3, the low quadword is `qsrc` when `mask_en` = 0 or `mask_bit` = 1. Otherwise it is `dst_old[63:0]` when `zero_mode` = 0, and 0 when `zero_mode` = 1.
- R7: Form code 4 (store): `st_data` = `vsrc1[63:0]` and `rf_we` = 0. `st_en` = 1 exactly when `mask_en` = 0 or `mask_bit` = 1, and `zero_mode` has no effect.
- R8: Form codes 3 and 4 with `xreg_field` other than 4'b1111 raise `ud_fault` and drive both `rf_we` and `st_en` low. Form codes 0 to 2 never fault on `xreg_field`.
- R9: Form codes 5, 6 and 7 are undefined: they raise `ud_fault` with `rf_we` and `st_en` low.
- R10: `rf_we` is set only for form codes 0 to 3 without a fault, and `rf_we` and `st_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| form | input | 3 | Operation form code (0 to 4 defined) |
| vsrc1 | input | 128 | First source register, low 128 bits; store source |
| qsrc | input | 64 | Second source low quadword or loaded memory quadword |
| dst_old | input | VW | Current destination register contents |
| mask_en | input | 1 | Masking in use |
| mask_bit | input | 1 | Mask bit 0 |
| zero_mode | input | 1 | 1 = zeroing, 0 = merging |
| xreg_field | input | 4 | Encoded extra-register field |
| out_valid | output | 1 | Result strobe |
| rf_we | output | 1 | Register write enable |
| rf_wdata | output | VW | New destination register value |
| st_en | output | 1 | Store enable |
| st_data | output | 64 | Store quadword |
| ud_fault | output | 1 | Undefined-opcode fault |

## Verification
The assertions check the following on every cycle:
- the one-cycle strobe timing and quiet idle outputs;
- that a fault blocks both write paths;
- that register and store writes never occur together;
- the upper-bit handling of the legacy register move and the masked load;
- the unmasked low-quadword copy.

Only the bench's sweep can show the full merge-versus-zero choice on the low quadword, the exact bit-range layout of every form, and `zero_mode` having no effect on stores. The sweep covers every form code, every mask-control combination and several extra-register field values, with data patterns that differ in every word.

// File: rtl/smw_pkg.sv
package smw_pkg;
  localparam int QW = 64;
  localparam int XW = 4;
  localparam logic [XW-1:0] XREG_NONE = 4'b1111;

  typedef enum logic [2:0] {
    SMW_REG = 3'd0,
    SMW_LDL = 3'd1,
    SMW_MRG = 3'd2,
    SMW_LDN = 3'd3,
    SMW_ST  = 3'd4
  } smw_form_e;

  // Forms whose low quadword is governed by the mask bit
  function automatic logic smw_is_masked(input logic [2:0] f);
    return (f == SMW_MRG) || (f == SMW_LDN);
  endfunction

  // Low-quadword selection under a single mask bit
  function automatic logic [QW-1:0] smw_lowq(input logic [QW-1:0] src,
                                             input logic [QW-1:0] old,
                                             input logic men, input logic mbit,
                                             input logic zmode);
    if (!men || mbit) return src;
    else if (zmode)   return '0;
    else              return old;
  endfunction

  // Bits 127:64 per form
  function automatic logic [QW-1:0] smw_midq(input logic [2:0] f,
                                             input logic [QW-1:0] old_mid,
                                             input logic [QW-1:0] s1_mid);
    case (f)
      SMW_LDL, SMW_LDN: return '0;
      SMW_MRG:          return s1_mid;
      default:          return old_mid;
    endcase
  endfunction

  // Whether bits above 127 are zeroed
  function automatic logic smw_clears_high(input logic [2:0] f);
    return (f == SMW_MRG) || (f == SMW_LDN);
  endfunction
endpackage

// File: rtl/smw_decode.sv
module smw_decode
  import smw_pkg::*;
(
  input  logic [2:0]    form,
  input  logic [XW-1:0] xreg_field,
  input  logic          mask_en,
  input  logic          mask_bit,
  output logic          ev_fault,
  output logic          ev_rf_sel,
  output logic          ev_st_sel
);
  logic known_form;
  logic needs_none;

  always_comb begin
    known_form = (form <= SMW_ST);
    needs_none = (form == SMW_LDN) || (form == SMW_ST);
    ev_fault   = !known_form || (needs_none && (xreg_field != XREG_NONE));
    ev_rf_sel  = !ev_fault && (form != SMW_ST);
    ev_st_sel  = !ev_fault && (form == SMW_ST) && (!mask_en || mask_bit);
  end
endmodule

// File: rtl/smw_compose.sv
module smw_compose
  import smw_pkg::*;
#(
  parameter int VW = 256
) (
  input  logic [2:0]    form,
  input  logic [127:0]  vsrc1,
  input  logic [QW-1:0] qsrc,
  input  logic [VW-1:0] dst_old,
  input  logic          mask_en,
  input  logic          mask_bit,
  input  logic          zero_mode,
  output logic [VW-1:0] wdata,
  output logic [QW-1:0] sdata
);
  logic [QW-1:0] low_q;
  logic [QW-1:0] mid_q;

  always_comb begin
    low_q = smw_is_masked(form)
          ? smw_lowq(qsrc, dst_old[QW-1:0], mask_en, mask_bit, zero_mode)
          : qsrc;
    mid_q = smw_midq(form, dst_old[127:64], vsrc1[127:64]);
    sdata = vsrc1[QW-1:0];
  end

  generate
    if (VW > 128) begin : g_wide
      localparam int HW = VW - 128;
      logic [HW-1:0] high_q;
      always_comb begin
        high_q = smw_clears_high(form) ? '0 : dst_old[VW-1:128];
        wdata  = {high_q, mid_q, low_q};
      end
    end else begin : g_narrow
      always_comb wdata = {mid_q, low_q};
    end
  endgenerate
endmodule

// File: rtl/scalar_merge_wb.sv
module scalar_merge_wb
  import smw_pkg::*;
#(
  parameter int VW = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    form,
  input  logic [127:0]  vsrc1,
  input  logic [63:0]   qsrc,
  input  logic [VW-1:0] dst_old,
  input  logic          mask_en,
  input  logic          mask_bit,
  input  logic          zero_mode,
  input  logic [3:0]    xreg_field,
  output logic          out_valid,
  output logic          rf_we,
  output logic [VW-1:0] rf_wdata,
  output logic          st_en,
  output logic [63:0]   st_data,
  output logic          ud_fault
);
  // Named internal events, visible to the checker
  logic          ev_fault;
  logic          ev_rf_sel;
  logic          ev_st_sel;
  logic [VW-1:0] nx_wdata;
  logic [QW-1:0] nx_sdata;

  smw_decode u_dec (
    .form       (form),
    .xreg_field (xreg_field),
    .mask_en    (mask_en),
    .mask_bit   (mask_bit),
    .ev_fault   (ev_fault),
    .ev_rf_sel  (ev_rf_sel),
    .ev_st_sel  (ev_st_sel)
  );

  smw_compose #(.VW(VW)) u_cmp (
    .form      (form),
    .vsrc1     (vsrc1),
    .qsrc      (qsrc),
    .dst_old   (dst_old),
    .mask_en   (mask_en),
    .mask_bit  (mask_bit),
    .zero_mode (zero_mode),
    .wdata     (nx_wdata),
    .sdata     (nx_sdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      rf_we     <= 1'b0;
      st_en     <= 1'b0;
      ud_fault  <= 1'b0;
      rf_wdata  <= '0;
      st_data   <= '0;
    end else begin
      out_valid <= in_valid;
      rf_we     <= in_valid && ev_rf_sel;
      st_en     <= in_valid && ev_st_sel;
      ud_fault  <= in_valid && ev_fault;
      if (in_valid) begin
        rf_wdata <= nx_wdata;
        st_data  <= nx_sdata;
      end
    end
  end
endmodule

// File: rtl/smw_chk.sv
module smw_chk #(
  parameter int VW = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [2:0]    form,
  input logic [63:0]   qsrc,
  input logic [VW-1:0] dst_old,
  input logic          mask_en,
  input logic          mask_bit,
  input logic          out_valid,
  input logic          rf_we,
  input logic [VW-1:0] rf_wdata,
  input logic          st_en,
  input logic          ud_fault,
  input logic          ev_fault
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!rf_we && !st_en && !ud_fault));
  // R8
  fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_fault) |=> (ud_fault && !rf_we && !st_en));
  // R10
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && st_en));
  // R2
  legacy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && form == 3'd0) |=> (rf_wdata[VW-1:64] == $past(dst_old[VW-1:64])));
  // R5
  newload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && form == 3'd3 && !ev_fault) |=> (rf_wdata[VW-1:64] == '0));
  // R6
  unmasked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (form == 3'd2 || form == 3'd3) && (!mask_en || mask_bit))
      |=> (rf_wdata[63:0] == $past(qsrc)));
  // R7
  store_noreg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && form == 3'd4) |=> !rf_we);
  // R9
  undef_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && form > 3'd4) |=> ud_fault);
endmodule

bind scalar_merge_wb smw_chk #(.VW(VW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .form      (form),
  .qsrc      (qsrc),
  .dst_old   (dst_old),
  .mask_en   (mask_en),
  .mask_bit  (mask_bit),
  .out_valid (out_valid),
  .rf_we     (rf_we),
  .rf_wdata  (rf_wdata),
  .st_en     (st_en),
  .ud_fault  (ud_fault),
  .ev_fault  (ev_fault)
);

// File: tb/scalar_merge_wb_tb_top.sv
`timescale 1ns/1ps
module scalar_merge_wb_tb_top;
  localparam int VW = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [2:0]    form = '0;
  logic [127:0]  vsrc1 = '0;
  logic [63:0]   qsrc = '0;
  logic [VW-1:0] dst_old = '0;
  logic          mask_en = 1'b0;
  logic          mask_bit = 1'b0;
  logic          zero_mode = 1'b0;
  logic [3:0]    xreg_field = 4'hF;
  logic          out_valid, rf_we, st_en, ud_fault;
  logic [VW-1:0] rf_wdata;
  logic [63:0]   st_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  scalar_merge_wb #(.VW(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .form(form),
    .vsrc1(vsrc1), .qsrc(qsrc), .dst_old(dst_old), .mask_en(mask_en),
    .mask_bit(mask_bit), .zero_mode(zero_mode), .xreg_field(xreg_field),
    .out_valid(out_valid), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .st_en(st_en), .st_data(st_data), .ud_fault(ud_fault)
  );

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] mkvec(input int seed, input int idx);
    logic [VW-1:0] v;
    for (int j = 0; j < VW/32; j++)
      v[j*32 +: 32] = 32'h9E3779B9 * (seed + j + 1) + 32'(idx) * 32'h01000193;
    return v;
  endfunction

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL R1 watchdog act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] xvals [4];
    xvals[0] = 4'hF; xvals[1] = 4'h0; xvals[2] = 4'h7; xvals[3] = 4'hE;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!out_valid && !rf_we && !st_en && !ud_fault && rf_wdata == '0 && st_data == '0,
        "R1", "reset outputs", VW'({out_valid, rf_we, st_en, ud_fault}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R1", "idle out_valid", VW'(out_valid), '0);

    for (int f = 0; f < 8; f++)
      for (int me = 0; me < 2; me++)
        for (int mb = 0; mb < 2; mb++)
          for (int zm = 0; zm < 2; zm++)
            for (int xi = 0; xi < 4; xi++) begin
              int idx;
              logic e_fault, e_we, e_st, unmask;
              logic [63:0] e_low;
              logic [VW-1:0] e_w;
              string dtag;
              idx = f*32 + me*16 + mb*8 + zm*4 + xi;
              in_valid   = 1'b1;
              form       = 3'(f);
              mask_en    = 1'(me);
              mask_bit   = 1'(mb);
              zero_mode  = 1'(zm);
              xreg_field = xvals[xi];
              vsrc1      = mkvec(11, idx)[127:0];
              qsrc       = mkvec(23, idx)[63:0];
              dst_old    = mkvec(37, idx);
              // expected values from the requirements
              e_fault = (f > 4) || ((f == 3 || f == 4) && xvals[xi] != 4'hF);
              e_we    = !e_fault && f < 4;
              e_st    = !e_fault && f == 4 && (me == 0 || mb == 1);
              unmask  = !(f == 2 || f == 3) || me == 0 || mb == 1;
              e_low   = unmask ? qsrc : (zm == 1 ? 64'd0 : dst_old[63:0]);
              for (int b = 0; b < VW; b++) begin
                if (b < 64) e_w[b] = e_low[b];
                else if (b < 128)
                  e_w[b] = (f == 0) ? dst_old[b] : (f == 2) ? vsrc1[b] : 1'b0;
                else
                  e_w[b] = (f < 2) ? dst_old[b] : 1'b0;
              end
              dtag = (f == 0) ? "R2" : (f == 1) ? "R3" : (f == 2) ? "R4" : "R5";
              if (!unmask) dtag = "R6";
              @(negedge clk);
              chk(out_valid == 1'b1, "R1", "out_valid", VW'(out_valid), VW'(1));
              chk(ud_fault == e_fault, (f > 4) ? "R9" : "R8", "ud_fault",
                  VW'(ud_fault), VW'(e_fault));
              chk(rf_we == e_we, "R10", "rf_we", VW'(rf_we), VW'(e_we));
              chk(st_en == e_st, "R7", "st_en", VW'(st_en), VW'(e_st));
              if (e_we) chk(rf_wdata == e_w, dtag, "rf_wdata", rf_wdata, e_w);
              if (e_st) chk(st_data == vsrc1[63:0], "R7", "st_data",
                            VW'(st_data), VW'(vsrc1[63:0]));
            end

    in_valid = 1'b0;
    @(negedge clk);
    // R1: strobe drops and enables go quiet one cycle after in_valid falls
    chk(!out_valid && !rf_we && !st_en && !ud_fault, "R1", "quiet after idle",
        VW'({out_valid, rf_we, st_en, ud_fault}), '0);
    @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule